// File: doc/BRIEF.md
# Hybrid PAL/PLA Product-Term Array

This block is the combinational heart of a programmable logic block. It receives 36 input signals and produces 16 macrocell logic outputs and 6 control-term outputs. Every macrocell output has its own five product terms merged by a fixed OR. On top of that, a pool of 32 shared product terms can be steered to any output through a programmable OR plane. A shared term can feed many outputs at once, so logic that several outputs have in common is built only once. Each of the six control terms can be set to work either as a product (AND of literals) or as a sum (OR of literals).

All AND-plane literal masks, the OR-plane selections and the control-term modes sit in configuration flops. Software fills them through a word-wide port while the logic using the array is idle. Writes are accepted only while the configuration enable is high. The outputs follow the inputs and the stored configuration with no clock latency.

Top module: `hpla_array`

## Requirements
- R1: A synchronous active-low reset clears all configuration. After reset, mc_out and ct_out are all zero for any input pattern.
- R2: A configuration word is stored only on a rising clock edge where both cfg_en and cfg_we are 1. A write with either one low changes nothing. A write to an address above 134 also changes nothing.
- R3: A literal mask is 72 bits wide. Bit i (0..35) enables the true literal of in_bus[i], and bit 36+i enables its complement. A product term is 1 when every enabled literal is 1.
- R4: A term with no enabled literal evaluates to 0. This holds for both product terms and control terms.
- R5: A product term with both polarities of the same input enabled always evaluates to 0.
- R6: mc_out[o] is 1 whenever any of its five dedicated terms is 1.
- R7: The OR-plane row of output o holds a 32-bit selection in cfg_wdata[31:0]. Bit s set adds shared term s into mc_out[o].
- R8: A single shared term that is selected by several rows drives all of those outputs at the same time.
- R9: One output can combine all 37 terms at once, that is its 5 dedicated terms and all 32 shared terms.
- R10: The mode word holds one bit per control term in cfg_wdata[5:0]. A bit value of 1 makes that control term a product and 0 makes it a sum. A sum is the OR of its enabled literals, and an empty sum is 0.
- R11: The address map is as follows. Dedicated term k of output o is at o*5+k (0..79). Shared term s is at 80+s. Control term c is at 112+c. The OR row of output o is at 118+o. The mode word is at 134.
- R12: Outputs respond to in_bus changes within the same cycle, with no clock edge needed. A configuration write takes effect right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset of the configuration |
| cfg_en | input | 1 | Configuration access enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 72 | Configuration write data |
| in_bus | input | 36 | Array input signals |
| mc_out | output | 16 | Macrocell sum-of-products outputs |
| ct_out | output | 6 | Control-term outputs |

## Verification
The embedded properties assume four things. Reset is held low from time zero. in_bus and the configuration port carry only defined 0/1 values once reset is released. The configuration changes only through the write port. Outputs are sampled after the combinational planes have settled.

The stimulus meets these assumptions as follows. It drives every input to a known value from the first instant and changes inputs only on falling clock edges. It samples one time step later, still before the next rising edge. Random configuration uses sparse literal masks so that product terms are true often enough to be seen. Disabled and out-of-range writes are mixed in.

// File: rtl/hpla_pkg.sv
// Package: shared default dimensions and the control-term mode type for
// the hybrid product-term array. Assumes nothing about its users.
package hpla_pkg;
    localparam int DEF_IN_CNT      = 36;
    localparam int DEF_OUT_CNT     = 16;
    localparam int DEF_DED_PER_OUT = 5;
    localparam int DEF_SHARED_CNT  = 32;
    localparam int DEF_CTRL_CNT    = 6;

    typedef enum logic {
        CT_SUM  = 1'b0,
        CT_PROD = 1'b1
    } ct_mode_e;
endpackage

// File: rtl/hpla_term.sv
// Module: evaluates one term over the input literals, either as a
// product (AND of enabled literals) or as a sum (OR of enabled literals).
// Assumes mask layout: low N_IN bits true-enable, high N_IN bits
// complement-enable. An empty mask yields 0 in both modes.
module hpla_term #(
    parameter int N_IN = 36,
    localparam int W   = 2 * N_IN
) (
    input  logic [N_IN-1:0] in_vec,
    input  logic [W-1:0]    lit_mask,
    input  logic            sum_mode,
    output logic            term_out
);
    logic [N_IN-1:0] t_en;
    logic [N_IN-1:0] c_en;
    logic            any_lit;
    logic            miss;
    logic            hit;

    // Purpose: split the mask and reduce literals for both term modes.
    always_comb begin
        t_en     = lit_mask[N_IN-1:0];
        c_en     = lit_mask[W-1:N_IN];
        any_lit  = |lit_mask;
        miss     = |((t_en & ~in_vec) | (c_en & in_vec));
        hit      = |((t_en & in_vec) | (c_en & ~in_vec));
        term_out = sum_mode ? hit : (any_lit & ~miss);
    end
endmodule

// File: rtl/hpla_cfg_regs.sv
// Module: configuration storage for all literal masks, OR-plane rows and
// control-term modes, written one word per clock through a word port.
// Assumes writes happen only while the array's consumer is idle.
module hpla_cfg_regs #(
    parameter int N_IN    = 36,
    parameter int N_OUT   = 16,
    parameter int N_TERMS = 118,
    parameter int N_SHR   = 32,
    parameter int N_CT    = 6,
    parameter int ADDR_W  = 8,
    localparam int W        = 2 * N_IN,
    localparam int ROW_BASE = N_TERMS,
    localparam int MODE_ADR = N_TERMS + N_OUT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_en,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [W-1:0]                  cfg_wdata,
    output logic [N_TERMS-1:0][W-1:0]     term_mask,
    output logic [N_OUT-1:0][N_SHR-1:0]   or_sel,
    output logic [N_CT-1:0]               ct_prod
);
    logic wr;

    // Purpose: qualify a write strobe with the configuration enable.
    always_comb wr = cfg_en & cfg_we;

    // Purpose: store literal masks addressed 0..N_TERMS-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_mask <= '0;
        end else begin
            for (int i = 0; i < N_TERMS; i++) begin
                if (wr && cfg_addr == ADDR_W'(i)) term_mask[i] <= cfg_wdata;
            end
        end
    end

    // Purpose: store OR-plane selection rows, one per output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            or_sel <= '0;
        end else begin
            for (int o = 0; o < N_OUT; o++) begin
                if (wr && cfg_addr == ADDR_W'(ROW_BASE + o)) or_sel[o] <= cfg_wdata[N_SHR-1:0];
            end
        end
    end

    // Purpose: store the per-control-term product/sum mode word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_prod <= '0;
        end else if (wr && cfg_addr == ADDR_W'(MODE_ADR)) begin
            ct_prod <= cfg_wdata[N_CT-1:0];
        end
    end

    // R2: without a qualified write the stored configuration holds.
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && cfg_we) |=> ($stable(term_mask) && $stable(or_sel) && $stable(ct_prod)));
endmodule

// File: rtl/hpla_array.sv
// Module: top of the hybrid PAL/PLA array. Builds every term, merges the
// dedicated terms of each output through a fixed OR and the shared terms
// through the programmable OR plane, and exposes the control terms.
// Assumes configuration is written only while outputs are not consumed.
module hpla_array
    import hpla_pkg::*;
#(
    parameter int N_IN  = DEF_IN_CNT,
    parameter int N_OUT = DEF_OUT_CNT,
    parameter int N_DED = DEF_DED_PER_OUT,
    parameter int N_SHR = DEF_SHARED_CNT,
    parameter int N_CT  = DEF_CTRL_CNT,
    localparam int W       = 2 * N_IN,
    localparam int N_DT    = N_OUT * N_DED,
    localparam int N_PT    = N_DT + N_SHR,
    localparam int N_TERMS = N_PT + N_CT,
    localparam int ADDR_W  = $clog2(N_TERMS + N_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [W-1:0]      cfg_wdata,
    input  logic [N_IN-1:0]   in_bus,
    output logic [N_OUT-1:0]  mc_out,
    output logic [N_CT-1:0]   ct_out
);
    logic [N_TERMS-1:0][W-1:0]   term_mask;
    logic [N_OUT-1:0][N_SHR-1:0] or_sel;
    logic [N_CT-1:0]             ct_prod;
    logic [N_TERMS-1:0]          pt;
    logic [N_SHR-1:0]            shr;

    hpla_cfg_regs #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_TERMS(N_TERMS),
        .N_SHR(N_SHR), .N_CT(N_CT), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .term_mask(term_mask), .or_sel(or_sel), .ct_prod(ct_prod)
    );

    // Term instances: plain product terms first, then control terms.
    for (genvar j = 0; j < N_TERMS; j++) begin : g_term
        logic mode_sum;
        if (j < N_PT) begin : g_pt
            always_comb mode_sum = 1'b0;
        end else begin : g_ct
            always_comb mode_sum = (ct_mode_e'(ct_prod[j-N_PT]) == CT_SUM);
        end
        hpla_term #(.N_IN(N_IN)) u_term (
            .in_vec(in_bus), .lit_mask(term_mask[j]),
            .sum_mode(mode_sum), .term_out(pt[j])
        );
    end

    // Purpose: gather the shared pool for the OR plane.
    always_comb shr = pt[N_PT-1:N_DT];

    // Per-output fixed OR of dedicated terms plus programmable OR of pool.
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        always_comb mc_out[o] = (|pt[o*N_DED +: N_DED]) | (|(shr & or_sel[o]));

        // R7: a selected shared term that is true forces the output high.
        assert_shared_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (|(shr & or_sel[o])) |-> mc_out[o]);

        for (genvar k = 0; k < N_DED; k++) begin : g_ded
            // R6: any true dedicated term forces its output high.
            assert_ded_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
                pt[o*N_DED+k] |-> mc_out[o]);
        end
    end

    // Purpose: expose the control terms.
    always_comb ct_out = pt[N_TERMS-1:N_PT];

    // Term-level checks on stored masks against evaluated terms.
    for (genvar j = 0; j < N_TERMS; j++) begin : g_chk
        // R4: an empty mask never produces a true term.
        assert_empty_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (term_mask[j] == '0) |-> !pt[j]);
        if (j < N_PT) begin : g_pc
            // R5: opposing literals of one input kill a product term.
            assert_contra_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (|(term_mask[j][W-1:N_IN] & term_mask[j][N_IN-1:0])) |-> !pt[j]);
        end else begin : g_cc
            // R5/R10: same rule for a control term in product mode.
            assert_ct_contra_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (ct_prod[j-N_PT] && (|(term_mask[j][W-1:N_IN] & term_mask[j][N_IN-1:0])))
                |-> !pt[j]);
        end
    end

    // R1: one cycle after reset is seen, every output is low.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (mc_out == '0 && ct_out == '0));
endmodule

// File: tb/sim_hpla_array.sv
// Bench: directed corner cases then seeded random configurations, all
// compared against a bench-side model of the requirements.
module sim_hpla_array;
    localparam int NI = 36, NO = 16, ND = 5, NS = 32, NC = 6;
    localparam int W = 2 * NI;
    localparam int A_SHR = NO * ND, A_CT = A_SHR + NS, A_ROW = A_CT + NC;
    localparam int A_MODE = A_ROW + NO, N_ADDR = A_MODE + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0, cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic [NI-1:0] in_bus = '0;
    logic [NO-1:0] mc_out;
    logic [NC-1:0] ct_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [W-1:0]  m_term [A_ROW];
    logic [NS-1:0] m_row  [NO];
    logic [NC-1:0] m_mode;

    hpla_array u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_bus(in_bus),
        .mc_out(mc_out), .ct_out(ct_out)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] tl(int i); return W'(1) << i; endfunction
    function automatic logic [W-1:0] cl(int i); return W'(1) << (NI + i); endfunction

    function automatic logic f_term(logic [W-1:0] m, logic [NI-1:0] x, logic is_sum);
        logic any = 0, hit = 0, miss = 0;
        for (int i = 0; i < NI; i++) begin
            if (m[i])      begin any = 1; if (x[i]) hit = 1; else miss = 1; end
            if (m[NI + i]) begin any = 1; if (!x[i]) hit = 1; else miss = 1; end
        end
        return is_sum ? hit : (any && !miss);
    endfunction

    function automatic logic [NO-1:0] exp_mc(logic [NI-1:0] x);
        logic [NO-1:0] r = '0;
        for (int o = 0; o < NO; o++) begin
            for (int k = 0; k < ND; k++) r[o] |= f_term(m_term[o*ND + k], x, 1'b0);
            for (int s = 0; s < NS; s++) if (m_row[o][s]) r[o] |= f_term(m_term[A_SHR + s], x, 1'b0);
        end
        return r;
    endfunction

    function automatic logic [NC-1:0] exp_ct(logic [NI-1:0] x);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = f_term(m_term[A_CT + c], x, !m_mode[c]);
        return r;
    endfunction

    function automatic logic [W-1:0] rand_mask();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = ($urandom_range(0, 23) == 0);
        return m;
    endfunction

    task automatic model_clear();
        for (int t = 0; t < A_ROW; t++) m_term[t] = '0;
        for (int o = 0; o < NO; o++) m_row[o] = '0;
        m_mode = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic cfg_wr(int a, logic [W-1:0] d, logic en, logic we);
        @(negedge clk);
        cfg_en = en; cfg_we = we; cfg_addr = 8'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
        if (en && we && a < N_ADDR) begin
            if (a < A_ROW) m_term[a] = d;
            else if (a < A_MODE) m_row[a - A_ROW] = d[NS-1:0];
            else m_mode = d[NC-1:0];
        end
    endtask

    // drive inputs mid-cycle and settle, no clock edge in between
    task automatic drive(logic [NI-1:0] x);
        @(negedge clk); in_bus = x; #1;
    endtask

    task automatic chk_bit(logic act, logic exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        logic [NO-1:0] em = exp_mc(in_bus);
        logic [NC-1:0] ec = exp_ct(in_bus);
        n_chk++;
        if (mc_out !== em) begin
            n_bad++;
            $display("FAIL %s mc_out: actual %h expected %h", req, mc_out, em);
        end
        n_chk++;
        if (ct_out !== ec) begin
            n_bad++;
            $display("FAIL %s ct_out: actual %h expected %h", req, ct_out, ec);
        end
    endtask

    function automatic logic [NI-1:0] rnd_in();
        return {4'($urandom), $urandom};
    endfunction

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        in_bus = rnd_in();
        do_reset();

        // R1: cleared configuration keeps everything low
        for (int v = 0; v < 3; v++) begin
            drive(rnd_in());
            chk_bit(|mc_out, 1'b0, "R1 mc_out after reset");
            chk_bit(|ct_out, 1'b0, "R1 ct_out after reset");
        end

        // R3: true literal, complement literal, multi-literal AND
        cfg_wr(0*ND + 0, tl(3), 1, 1);
        drive(NI'(1) << 3);   chk_bit(mc_out[0], 1'b1, "R3 true literal hit");
        drive('1 ^ (NI'(1) << 3)); chk_bit(mc_out[0], 1'b0, "R3 true literal miss");
        cfg_wr(0*ND + 1, cl(5), 1, 1);
        drive('0);            chk_bit(mc_out[0], 1'b1, "R6 complement term ORed in");
        drive(NI'(1) << 5);   chk_bit(mc_out[0], 1'b0, "R3 complement literal miss");
        cfg_wr(0*ND + 2, tl(7) | tl(8), 1, 1);
        drive((NI'(1) << 5) | (NI'(1) << 7)); chk_bit(mc_out[0], 1'b0, "R3 partial AND");
        drive((NI'(1) << 5) | (NI'(1) << 7) | (NI'(1) << 8)); chk_bit(mc_out[0], 1'b1, "R3 full AND");

        // R5: both polarities of one input in a term
        cfg_wr(1*ND + 0, tl(2) | cl(2), 1, 1);
        drive('0);            chk_bit(mc_out[1], 1'b0, "R5 contradiction x=0");
        drive('1);            chk_bit(mc_out[1], 1'b0, "R5 contradiction x=1");

        // R4: unprogrammed output stays low for extreme inputs
        drive('1);            chk_bit(mc_out[2], 1'b0, "R4 empty terms all-ones");
        drive('0);            chk_bit(mc_out[2], 1'b0, "R4 empty terms all-zeros");

        // R2: disabled, non-write and out-of-range accesses are ignored
        cfg_wr(3*ND + 0, tl(0), 0, 1);
        cfg_wr(3*ND + 1, tl(0), 1, 0);
        cfg_wr(200, '1, 1, 1);
        drive(36'h1);         chk_bit(mc_out[3], 1'b0, "R2 ignored writes");
        chk_all("R2 no side effect");

        // R7/R8: one shared term on two outputs
        cfg_wr(A_SHR + 0, tl(10), 1, 1);
        cfg_wr(A_ROW + 4, W'(1), 1, 1);
        cfg_wr(A_ROW + 5, W'(1), 1, 1);
        drive(NI'(1) << 10);
        chk_bit(mc_out[4], 1'b1, "R7 selected shared term");
        chk_bit(mc_out[5], 1'b1, "R8 shared term second output");
        chk_bit(mc_out[6], 1'b0, "R7 unselected output");
        drive('0);            chk_bit(mc_out[4] | mc_out[5], 1'b0, "R8 shared term false");

        // R9: output using all 37 terms, last shared and last dedicated
        cfg_wr(A_SHR + 31, tl(20), 1, 1);
        cfg_wr(6*ND + 4, tl(21), 1, 1);
        cfg_wr(A_ROW + 6, W'(32'hFFFF_FFFF), 1, 1);
        drive(NI'(1) << 20);  chk_bit(mc_out[6], 1'b1, "R9 shared term 31");
        drive(NI'(1) << 21);  chk_bit(mc_out[6], 1'b1, "R9 dedicated term 4");
        drive(NI'(1) << 22);  chk_bit(mc_out[6], 1'b0, "R9 none true");

        // R10: sum and product control terms, empty sum
        cfg_wr(A_CT + 0, tl(1) | tl(2), 1, 1);
        cfg_wr(A_CT + 1, tl(1) | tl(2), 1, 1);
        cfg_wr(A_CT + 3, tl(4) | cl(4), 1, 1);
        cfg_wr(A_MODE, W'(6'b001010), 1, 1);
        drive(NI'(1) << 1);
        chk_bit(ct_out[0], 1'b1, "R10 sum one literal");
        chk_bit(ct_out[1], 1'b0, "R10 product partial");
        drive(NI'(6));        chk_bit(ct_out[1], 1'b1, "R10 product full");
        drive('0);            chk_bit(ct_out[0], 1'b0, "R10 sum none");
        drive('1);
        chk_bit(ct_out[2], 1'b0, "R10 empty sum");
        chk_bit(ct_out[3], 1'b0, "R10 product contradiction");

        // R12: input change between edges seen immediately
        @(posedge clk); #2; in_bus = NI'(1) << 10; #1;
        chk_bit(mc_out[4], 1'b1, "R12 combinational rise");
        #1; in_bus = '0; #1;
        chk_bit(mc_out[4], 1'b0, "R12 combinational fall");

        // R11: random full configurations over the address map
        for (int r = 0; r < 3; r++) begin
            do_reset();
            for (int a = 0; a < N_ADDR; a++) begin
                if (a < A_ROW) cfg_wr(a, rand_mask(), 1, 1);
                else cfg_wr(a, {40'($urandom), $urandom}, 1, 1);
                if (a % 16 == 0) cfg_wr(int'($urandom_range(0, 255)), '1, 0, 1);
            end
            for (int v = 0; v < 200; v++) begin
                drive(rnd_in());
                chk_all("R11 random");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule